// File: doc/BRIEF.md
# Reflected CRC-16 Byte Engine

This block keeps the running 16-bit checksum for binary serial frames. A frame is opened with a one-clock `start_i` pulse, which sets the register to all ones. Message bytes then arrive over a valid/ready handshake. An accepted byte is folded into the low eight bits of the register. The engine then spends eight clocks on single-bit right shifts. Each shift fills the top bit with zero and applies the reflected polynomial A001h whenever the bit shifted out was a one.

The register is always visible on `crc_o`. It is also split into the byte that goes on the line first (`crc_lo_o`, bits 7:0) and the byte that follows it (`crc_hi_o`, bits 15:8). A receiver can present the two checksum bytes it captured, in arrival order. `match_o` then reports whether the finished register equals them.

Control is a two-state machine. In `ST_IDLE` the engine is ready and waits for input. The transition `ST_IDLE -> ST_SHIFT` is taken on an accepted byte. `ST_SHIFT` stays put while it counts shifts. The transition `ST_SHIFT -> ST_IDLE` is taken after the eighth shift. A start pulse forces the transition from either state back to `ST_IDLE`.

Top module: `crc16r_engine`

## Requirements
- R1: After reset the register reads FFFFh, `in_ready_o` is 1 and `match_o` reflects that value.
- R2: A `start_i` pulse loads FFFFh on the next clock edge from either state. If it arrives mid-byte, the byte is abandoned and `in_ready_o` is 1 after that edge. In the same cycle as `in_valid_i`, start wins and the byte is discarded.
- R3: A byte is accepted on a clock edge where `in_valid_i` and `in_ready_o` are both 1 and `start_i` is 0. On that edge, the byte is XORed into bits 7:0 and bits 15:8 are left as they were. With no accept, no shift and no start, the register holds.
- R4: On each of the eight edges that follow an accept, the register shifts right by one with zero fill into bit 15. When the bit leaving bit 0 was 1, the result is also XORed with A001h.
- R5: `in_ready_o` is 0 for exactly eight clocks after an accept. `in_valid_i` and `in_data_i` have no effect during those clocks.
- R6: `crc_lo_o` carries register bits 7:0, the byte transmitted first. `crc_hi_o` carries bits 15:8, transmitted second. `crc_o` is the whole register.
- R7: `match_o` is 1 only when the engine is ready and the register equals {`rx_second_i`, `rx_first_i`}, that is, with the first received byte as the low byte.
- R8: The ASCII string "123456789" yields 4B37h. Bytes 01 03 00 00 00 01 yield 0A84h. Those six bytes followed by their checksum sent low byte first (84 0A) yield 0000h.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Synchronous start-of-message clear |
| in_valid_i | input | 1 | Byte offered |
| in_data_i | input | 8 | Message byte |
| in_ready_o | output | 1 | Engine can accept a byte |
| crc_o | output | 16 | Running checksum register |
| crc_lo_o | output | 8 | Checksum byte sent first (bits 7:0) |
| crc_hi_o | output | 8 | Checksum byte sent second (bits 15:8) |
| rx_first_i | input | 8 | First received checksum byte |
| rx_second_i | input | 8 | Second received checksum byte |
| match_o | output | 1 | Register equals the received checksum |

## Verification
The bench goes after four corner cases.

- **Shift count.** It counts the clocks during which ready is low after each accept. An engine that stopped after seven shifts, or ran nine, produces checksums that disagree with the standard check string. It also fails the zero residue left after a message followed by its own checksum.
- **Input during shifting.** It offers different data while the engine is busy. A design that sampled input during that time would fold in an extra byte.
- **Start mid-byte.** It pulses start part way through a byte. A design that ignored the abort would finish with a corrupted value instead of FFFFh.
- **Start and valid together.** It raises start and valid in the same cycle. A design that let the byte through would leave a non-FFFFh register.

Byte-order mistakes on the outputs or in the match compare are caught by presenting the received checksum both correctly and swapped.

// File: rtl/crc16r_pkg.sv
package crc16r_pkg;

    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_SHIFT = 1'b1
    } eng_state_e;

    localparam int unsigned CRC_W_DEF  = 16;
    localparam int unsigned DATA_W_DEF = 8;
    localparam logic [15:0] POLY_DEF  = 16'hA001;
    localparam logic [15:0] INIT_DEF  = 16'hFFFF;

endpackage

// File: rtl/crc16r_step.sv
module crc16r_step #(
    parameter int unsigned    CRC_W = 16,
    parameter logic [CRC_W-1:0] POLY = 16'hA001
) (
    input  logic [CRC_W-1:0] crc_i,
    output logic [CRC_W-1:0] crc_o
);

    logic [CRC_W-1:0] shifted;

    always_comb begin
        shifted = {1'b0, crc_i[CRC_W-1:1]};
        if (crc_i[0]) begin
            crc_o = shifted ^ POLY;
        end else begin
            crc_o = shifted;
        end
    end

endmodule

// File: rtl/crc16r_ctrl.sv
module crc16r_ctrl
    import crc16r_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic in_valid_i,
    output logic in_ready_o,
    output logic load_init_o,
    output logic absorb_o,
    output logic shift_o
);

    localparam int unsigned CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

    eng_state_e       state_q;
    logic [CNT_W-1:0] cnt_q;

    // state register and shift counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else if (start_i) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (in_valid_i) begin
                        state_q <= ST_SHIFT;
                        cnt_q   <= '0;
                    end
                end
                ST_SHIFT: begin
                    if (cnt_q == LAST) begin
                        state_q <= ST_IDLE;
                        cnt_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: begin
                    state_q <= ST_IDLE;
                    cnt_q   <= '0;
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        in_ready_o  = 1'b0;
        absorb_o    = 1'b0;
        shift_o     = 1'b0;
        load_init_o = start_i;
        unique case (state_q)
            ST_IDLE: begin
                in_ready_o = 1'b1;
                absorb_o   = in_valid_i && !start_i;
            end
            ST_SHIFT: begin
                shift_o = !start_i;
            end
            default: begin
                in_ready_o = 1'b0;
            end
        endcase
    end

    // R5
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        absorb_o |=> !in_ready_o);

    // R5
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SHIFT && cnt_q == LAST && !start_i) |=> in_ready_o);

    // R5
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SHIFT && cnt_q != LAST && !start_i) |=> !in_ready_o);

    // R2
    abort_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> in_ready_o);

endmodule

// File: rtl/crc16r_engine.sv
module crc16r_engine
    import crc16r_pkg::*;
#(
    parameter int unsigned      DATA_W = DATA_W_DEF,
    parameter int unsigned      CRC_W  = CRC_W_DEF,
    parameter logic [CRC_W-1:0] POLY   = POLY_DEF,
    parameter logic [CRC_W-1:0] INIT   = INIT_DEF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              in_valid_i,
    input  logic [DATA_W-1:0] in_data_i,
    output logic              in_ready_o,
    output logic [CRC_W-1:0]  crc_o,
    output logic [7:0]        crc_lo_o,
    output logic [7:0]        crc_hi_o,
    input  logic [7:0]        rx_first_i,
    input  logic [7:0]        rx_second_i,
    output logic              match_o
);

    localparam int unsigned PAD_W = CRC_W - DATA_W;

    logic             load_init;
    logic             absorb;
    logic             shift;
    logic [CRC_W-1:0] crc_q;
    logic [CRC_W-1:0] crc_stepped;
    logic [CRC_W-1:0] data_ext;

    crc16r_ctrl #(.DATA_W(DATA_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .in_valid_i  (in_valid_i),
        .in_ready_o  (in_ready_o),
        .load_init_o (load_init),
        .absorb_o    (absorb),
        .shift_o     (shift)
    );

    crc16r_step #(.CRC_W(CRC_W), .POLY(POLY)) u_step (
        .crc_i (crc_q),
        .crc_o (crc_stepped)
    );

    generate
        if (PAD_W == 0) begin : g_nopad
            assign data_ext = in_data_i;
        end else begin : g_pad
            assign data_ext = {{PAD_W{1'b0}}, in_data_i};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            crc_q <= INIT;
        end else if (load_init) begin
            crc_q <= INIT;
        end else if (absorb) begin
            crc_q <= crc_q ^ data_ext;
        end else if (shift) begin
            crc_q <= crc_stepped;
        end
    end

    always_comb begin
        crc_o    = crc_q;
        crc_lo_o = crc_q[7:0];
        crc_hi_o = crc_q[15:8];
        match_o  = in_ready_o && (crc_q[15:0] == {rx_second_i, rx_first_i});
    end

    // R2
    start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> crc_q == INIT);

    // R3
    absorb_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid_i && in_ready_o && !start_i) |=> crc_q[CRC_W-1:DATA_W] == $past(crc_q[CRC_W-1:DATA_W]));

    // R3
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_ready_o && !in_valid_i && !start_i) |=> $stable(crc_q));

    // R4
    zero_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_ready_o && !start_i) |=> crc_q[CRC_W-1] == (POLY[CRC_W-1] & $past(crc_q[0])));

    // R7
    match_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        match_o |-> in_ready_o);

endmodule

// File: tb/crc16r_engine_bench.sv
module crc16r_engine_bench;

    localparam time CLK_PERIOD = 10ns;
    localparam int  NVEC = 4;

    localparam logic [71:0] VEC_MSG [NVEC] = '{
        72'h313233343536373839,
        72'h010300000001000000,
        72'h010300000001840A00,
        72'h000000000000000000
    };
    localparam int VEC_LEN [NVEC] = '{9, 6, 8, 0};
    localparam logic [15:0] VEC_EXP [NVEC] = '{16'h4B37, 16'h0A84, 16'h0000, 16'hFFFF};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        in_valid_i = 1'b0;
    logic [7:0]  in_data_i = 8'h00;
    logic        in_ready_o;
    logic [15:0] crc_o;
    logic [7:0]  crc_lo_o;
    logic [7:0]  crc_hi_o;
    logic [7:0]  rx_first_i = 8'h00;
    logic [7:0]  rx_second_i = 8'h00;
    logic        match_o;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    crc16r_engine u_crc16r_engine (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .in_valid_i  (in_valid_i),
        .in_data_i   (in_data_i),
        .in_ready_o  (in_ready_o),
        .crc_o       (crc_o),
        .crc_lo_o    (crc_lo_o),
        .crc_hi_o    (crc_hi_o),
        .rx_first_i  (rx_first_i),
        .rx_second_i (rx_second_i),
        .match_o     (match_o)
    );

    function automatic logic [15:0] model_byte(input logic [15:0] c, input logic [7:0] b);
        logic [15:0] r;
        r = c ^ {8'h00, b};
        for (int i = 0; i < 8; i++) begin
            r = r[0] ? ((r >> 1) ^ 16'hA001) : (r >> 1);
        end
        return r;
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic pulse_start();
        @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic send(input logic [7:0] b);
        @(negedge clk);
        in_valid_i = 1'b1;
        in_data_i  = b;
        while (!in_ready_o) @(negedge clk);
        @(negedge clk);
        in_valid_i = 1'b0;
        while (!in_ready_o) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual %0d expected %0d", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int cnt;
        rx_first_i  = 8'hFF;
        rx_second_i = 8'hFF;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 crc", crc_o, 16'hFFFF);
        check("R1 ready", {15'd0, in_ready_o}, 16'd1);
        check("R1 match", {15'd0, match_o}, 16'd1);
        rst_n = 1'b1;

        // R8 / R6 vector table
        for (int v = 0; v < NVEC; v++) begin
            pulse_start();
            for (int i = 0; i < VEC_LEN[v]; i++) begin
                send(VEC_MSG[v][71 - 8*i -: 8]);
            end
            @(negedge clk);
            check("R8 vector crc", crc_o, VEC_EXP[v]);
            check("R6 byte order", {crc_hi_o, crc_lo_o}, VEC_EXP[v]);
        end

        // R7 match with check string result
        pulse_start();
        for (int i = 0; i < 9; i++) send(VEC_MSG[0][71 - 8*i -: 8]);
        rx_first_i  = 8'h37;
        rx_second_i = 8'h4B;
        @(negedge clk);
        check("R7 match low-first", {15'd0, match_o}, 16'd1);
        check("R6 first byte", {8'h00, crc_lo_o}, 16'h0037);
        rx_first_i  = 8'h4B;
        rx_second_i = 8'h37;
        @(negedge clk);
        check("R7 swapped no match", {15'd0, match_o}, 16'd0);

        // R5 ready low exactly eight clocks
        pulse_start();
        @(negedge clk);
        in_valid_i = 1'b1;
        in_data_i  = 8'h31;
        @(negedge clk);
        in_valid_i = 1'b0;
        cnt = 0;
        while (!in_ready_o && cnt < 20) begin
            cnt++;
            @(negedge clk);
        end
        check("R5 busy clocks", 16'(cnt), 16'd8);
        check("R4 single byte", crc_o, model_byte(16'hFFFF, 8'h31));

        // R5 input ignored while shifting
        pulse_start();
        @(negedge clk);
        in_valid_i = 1'b1;
        in_data_i  = 8'h01;
        @(negedge clk);
        in_data_i = 8'hAA;
        repeat (3) @(negedge clk);
        in_valid_i = 1'b0;
        while (!in_ready_o) @(negedge clk);
        @(negedge clk);
        check("R5 busy input ignored", crc_o, model_byte(16'hFFFF, 8'h01));

        // R2 abort mid-byte
        pulse_start();
        send(8'h12);
        @(negedge clk);
        in_valid_i = 1'b1;
        in_data_i  = 8'h55;
        @(negedge clk);
        in_valid_i = 1'b0;
        repeat (2) @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check("R2 abort crc", crc_o, 16'hFFFF);
        check("R2 abort ready", {15'd0, in_ready_o}, 16'd1);
        send(8'hC3);
        @(negedge clk);
        check("R3 after abort", crc_o, model_byte(16'hFFFF, 8'hC3));

        // R2 start beats valid
        @(negedge clk);
        start_i    = 1'b1;
        in_valid_i = 1'b1;
        in_data_i  = 8'h42;
        @(negedge clk);
        start_i    = 1'b0;
        in_valid_i = 1'b0;
        check("R2 start wins crc", crc_o, 16'hFFFF);
        check("R2 start wins ready", {15'd0, in_ready_o}, 16'd1);

        // R3 hold with no input
        send(8'h80);
        repeat (5) @(negedge clk);
        check("R3 hold", crc_o, model_byte(16'hFFFF, 8'h80));

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule